// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

The bridge lets an external processor with an 8-bit asynchronous bus reach a 16-bit internal shared memory and a small control register. Each 16-bit word travels as two bytes: a half-select pin says whether the byte is the low (first) or high (second) half. Two select pins choose the target: the control register, the memory address register, or the memory data window (with or without address auto-increment). All host pins are brought into the core clock domain through two-flop synchronizers. A state machine then carries out the access on a simple synchronous RAM port with one cycle of read latency.

The host may drive separate read and write strobes or one data strobe with a read/write select line. For multiplexed buses, an address strobe can capture the select and half-select lines. A ready output goes low as soon as a strobe arrives and stays low until the internal work is done, so a fast host is slowed down without any software handshake. Interrupts run both ways: a control write raises a request to the core, and the core can pull an active-low line to the host, which the host clears through the control register.

The state machine has four states. `ST_IDLE` waits for a synchronized strobe. `ST_MEM` drives the RAM port for one cycle. `ST_CAPT` takes in read data or advances the address after a write. `ST_HOLD` waits for the strobe to be released. The transitions are:
- `ST_IDLE`→`ST_MEM` on a data-window access that needs memory: the first byte of a read or the second byte of a write.
- `ST_IDLE`→`ST_HOLD` on any other access.
- `ST_MEM`→`ST_CAPT` always.
- `ST_CAPT`→`ST_HOLD` always.
- `ST_HOLD`→`ST_IDLE` once the synchronized strobe is inactive.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, hrdy=1, hint_n=1, core_irq=0, mem_en=0 and hd_oe=0.
- R2: A write to the data window changes memory only when the second byte arrives (hhl=1), writing {second byte, first byte}. A first byte (hhl=0) alone causes no memory write.
- R3: A read of the first byte (hhl=0) from the data window fetches the whole word with exactly one memory read and returns bits 7:0. A read of the second byte returns bits 15:8 with no memory access.
- R4: The select code hsel chooses the target. 00 is the control register, 01 is data with auto-increment, 10 is the address register and 11 is data without increment. With 01 the address advances by one after the second byte; with 11 it does not change.
- R5: A completed control write with bit 0 set drives core_irq high. core_irq then stays high until core_irq_ack, and core_irq_ack wins over a write in the same cycle.
- R6: A core_hint_set pulse drives hint_n low, and the set wins over a clear in the same cycle. A control write with bit 1 set releases hint_n. A control read returns the host interrupt in bit 1 and core_irq in bit 0.
- R7: With use_rw=0 the strobes are hrd_n and hwr_n. With use_rw=1 the strobe is hds_n and the direction is hrw (1=read).
- R8: With use_as=1, hsel and hhl are taken at the falling edge of has_n, and later changes on those pins before the strobe are ignored.
- R9: hrdy goes low as soon as a selected strobe appears and stays low until the access completes. A memory access keeps it low for at least two core cycles, and hrdy is low whenever mem_en is high.
- R10: While hcs_n is high, strobes are ignored: no memory access and no drop of hrdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe (use_rw=0) |
| hwr_n | input | 1 | Host write strobe (use_rw=0) |
| hds_n | input | 1 | Host data strobe (use_rw=1) |
| hrw | input | 1 | Direction for hds_n, 1=read |
| has_n | input | 1 | Address strobe, falling edge captures select lines |
| hsel | input | 2 | Target select code |
| hhl | input | 1 | Half select, 0=first/low byte, 1=second/high byte |
| hd_in | input | 8 | Host write data |
| hd_out | output | 8 | Host read data |
| hd_oe | output | 1 | Read data valid, drive enable for the host bus |
| hrdy | output | 1 | Ready, low inserts wait states |
| hint_n | output | 1 | Interrupt to host, active low |
| use_rw | input | 1 | Strobe style select, static |
| use_as | input | 1 | Use address-strobe latching, static |
| core_irq | output | 1 | Interrupt request to the core |
| core_irq_ack | input | 1 | Core clears core_irq |
| core_hint_set | input | 1 | Core raises the host interrupt |
| mem_en | output | 1 | RAM port enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after mem_en |

## Verification
The assertions assume that use_rw and use_as stay fixed while a strobe is active. They also assume hsel, hhl and hd_in are stable for several core cycles around the strobe, and that the host waits for hrdy before it ends an access. The bench keeps to these limits by setting the pins three cycles before each strobe. It holds the strobe until hrdy returns and waits four cycles after release. In address-strobe mode it deliberately corrupts hsel and hhl after has_n rises, so only the captured values can be used.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADDR = 2'b10,
        SEL_DFIX = 2'b11
    } hsel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_CAPT,
        ST_HOLD
    } hpb_state_e;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= INIT;
            s2 <= INIT;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/hpb_front.sv
module hpb_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_rw,
    input  logic       use_as,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       ds_n,
    input  logic       rw,
    input  logic       as_n,
    input  logic [1:0] sel_in,
    input  logic       hl_in,
    output logic       act,
    output logic       is_rd,
    output logic [1:0] sel_o,
    output logic       hl_o
);
    logic       as_prev;
    logic [1:0] sel_lat;
    logic       hl_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_prev <= 1'b1;
            sel_lat <= '0;
            hl_lat  <= 1'b0;
        end else begin
            as_prev <= as_n;
            if (as_prev && !as_n) begin
                sel_lat <= sel_in;
                hl_lat  <= hl_in;
            end
        end
    end

    assign act   = !cs_n && (use_rw ? !ds_n : (!rd_n || !wr_n));
    assign is_rd = use_rw ? rw : !rd_n;
    assign sel_o = use_as ? sel_lat : sel_in;
    assign hl_o  = use_as ? hl_lat  : hl_in;
endmodule

// File: rtl/hpb_core.sv
module hpb_core
    import hpb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              is_rd,
    input  logic [1:0]        sel,
    input  logic              hl,
    input  logic [BYTE_W-1:0] din,
    input  logic              raw_act,
    input  logic              core_irq_ack,
    input  logic              core_hint_set,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] dout,
    output logic              oe,
    output logic              hrdy,
    output logic              hint_n,
    output logic              core_irq,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    hpb_state_e state_q, state_d;
    logic [BYTE_W-1:0] stage_q;
    logic [WORD_W-1:0] rlat_q, wdata_q, word;
    logic [AW-1:0]     addr_q;
    logic              acc_rd_q, hint_q, irq_q;
    hsel_e             acc_sel_q;
    hsel_e             sel_e;
    logic              is_data;

    assign sel_e   = hsel_e'(sel);
    assign is_data = (sel_e == SEL_DINC) || (sel_e == SEL_DFIX);
    assign word    = {din, stage_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (act) state_d = (is_data && (is_rd != hl)) ? ST_MEM : ST_HOLD;
            ST_MEM:  state_d = ST_CAPT;
            ST_CAPT: state_d = ST_HOLD;
            ST_HOLD: if (!act) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en = (state_q == ST_MEM);
        mem_we = (state_q == ST_MEM) && !acc_rd_q;
        hrdy   = !((state_q == ST_MEM) || (state_q == ST_CAPT) ||
                   ((state_q == ST_IDLE) && raw_act));
        oe     = (state_q == ST_HOLD) && acc_rd_q && raw_act;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q   <= '0;
            rlat_q    <= '0;
            wdata_q   <= '0;
            addr_q    <= '0;
            dout      <= '0;
            acc_rd_q  <= 1'b0;
            acc_sel_q <= SEL_CTRL;
            hint_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && act) begin
                acc_rd_q  <= is_rd;
                acc_sel_q <= sel_e;
                if (!is_rd && !hl) begin
                    stage_q <= din;
                end else if (!is_rd && hl) begin
                    unique case (sel_e)
                        SEL_CTRL: begin
                            if (word[0]) irq_q  <= 1'b1;
                            if (word[1]) hint_q <= 1'b0;
                        end
                        SEL_ADDR: addr_q  <= word[AW-1:0];
                        default:  wdata_q <= word;
                    endcase
                end else if (is_rd && !hl) begin
                    unique case (sel_e)
                        SEL_CTRL: begin
                            rlat_q <= {{(WORD_W-2){1'b0}}, hint_q, irq_q};
                            dout   <= {{(BYTE_W-2){1'b0}}, hint_q, irq_q};
                        end
                        SEL_ADDR: begin
                            rlat_q <= {{(WORD_W-AW){1'b0}}, addr_q};
                            dout   <= addr_q[BYTE_W-1:0];
                        end
                        default: ;
                    endcase
                end else begin
                    dout <= rlat_q[WORD_W-1:BYTE_W];
                    if (sel_e == SEL_DINC) addr_q <= addr_q + 1'b1;
                end
            end
            if (state_q == ST_CAPT) begin
                if (acc_rd_q) begin
                    rlat_q <= mem_rdata;
                    dout   <= mem_rdata[BYTE_W-1:0];
                end else if (acc_sel_q == SEL_DINC) begin
                    addr_q <= addr_q + 1'b1;
                end
            end
            if (core_irq_ack)  irq_q  <= 1'b0;
            if (core_hint_set) hint_q <= 1'b1;
        end
    end

    assign hint_n    = !hint_q;
    assign core_irq  = irq_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hcs_n,
    input  logic          hrd_n,
    input  logic          hwr_n,
    input  logic          hds_n,
    input  logic          hrw,
    input  logic          has_n,
    input  logic [1:0]    hsel,
    input  logic          hhl,
    input  logic [7:0]    hd_in,
    output logic [7:0]    hd_out,
    output logic          hd_oe,
    output logic          hrdy,
    output logic          hint_n,
    input  logic          use_rw,
    input  logic          use_as,
    output logic          core_irq,
    input  logic          core_irq_ack,
    input  logic          core_hint_set,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    localparam int CTL_W = 6;
    localparam int BUS_W = 2 + 1 + 8;

    logic [CTL_W-1:0] ctl_s;
    logic [BUS_W-1:0] bus_s;
    logic             act, is_rd, hl_f, raw_act;
    logic [1:0]       sel_f;

    hpb_sync #(.W(CTL_W), .INIT({CTL_W{1'b1}})) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({hcs_n, hrd_n, hwr_n, hds_n, hrw, has_n}), .q(ctl_s));

    hpb_sync #(.W(BUS_W), .INIT('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .d({hsel, hhl, hd_in}), .q(bus_s));

    hpb_front u_front (
        .clk(clk), .rst_n(rst_n), .use_rw(use_rw), .use_as(use_as),
        .cs_n(ctl_s[5]), .rd_n(ctl_s[4]), .wr_n(ctl_s[3]), .ds_n(ctl_s[2]),
        .rw(ctl_s[1]), .as_n(ctl_s[0]), .sel_in(bus_s[10:9]), .hl_in(bus_s[8]),
        .act(act), .is_rd(is_rd), .sel_o(sel_f), .hl_o(hl_f));

    assign raw_act = !hcs_n && (use_rw ? !hds_n : (!hrd_n || !hwr_n));

    hpb_core #(.AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .act(act), .is_rd(is_rd), .sel(sel_f),
        .hl(hl_f), .din(bus_s[7:0]), .raw_act(raw_act),
        .core_irq_ack(core_irq_ack), .core_hint_set(core_hint_set),
        .mem_rdata(mem_rdata), .dout(hd_out), .oe(hd_oe), .hrdy(hrdy),
        .hint_n(hint_n), .core_irq(core_irq), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));
endmodule

// File: rtl/hpb_chk.sv
module hpb_chk (
    input logic clk,
    input logic rst_n,
    input logic hrdy,
    input logic hint_n,
    input logic core_irq,
    input logic core_irq_ack,
    input logic core_hint_set,
    input logic mem_en
);
    // R9
    mem_hides_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !hrdy);

    // R9
    ready_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !hrdy);

    // R3
    single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    // R5
    irq_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_ack |=> !core_irq);

    // R6
    hint_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_hint_set |=> !hint_n);
endmodule

bind hostport_bridge hpb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hrdy(hrdy), .hint_n(hint_n),
    .core_irq(core_irq), .core_irq_ack(core_irq_ack),
    .core_hint_set(core_hint_set), .mem_en(mem_en));

// File: tb/tb_hostport_bridge.sv
module tb_hostport_bridge;
    localparam int AW = 8;
    localparam int NW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1, hds_n = 1'b1, hrw = 1'b0, has_n = 1'b1;
    logic [1:0] hsel = 2'b00;
    logic hhl = 1'b0;
    logic [7:0] hd_in = 8'h00;
    logic [7:0] hd_out;
    logic hd_oe, hrdy, hint_n, core_irq, mem_en, mem_we;
    logic use_rw = 1'b0, use_as = 1'b0, core_irq_ack = 1'b0, core_hint_set = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;

    logic [15:0] ram [0:(1<<AW)-1];
    int wr_cnt = 0, rd_cnt = 0;
    int nchk = 0, nerr = 0;
    int last_low = 0;
    logic last_drop = 1'b0;
    logic last_oe = 1'b0;

    always #4 clk = !clk;

    hostport_bridge #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
        .hds_n(hds_n), .hrw(hrw), .has_n(has_n), .hsel(hsel), .hhl(hhl),
        .hd_in(hd_in), .hd_out(hd_out), .hd_oe(hd_oe), .hrdy(hrdy),
        .hint_n(hint_n), .use_rw(use_rw), .use_as(use_as), .core_irq(core_irq),
        .core_irq_ack(core_irq_ack), .core_hint_set(core_hint_set),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                ram[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= ram[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [15:0] pat(input int i, input int salt);
        return 16'((i * 16'h1357 + salt) ^ (i << 9));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_op(input bit rd, input logic [1:0] sel, input bit hl,
                           input logic [7:0] wb, input bit cs, output logic [7:0] rb);
        @(negedge clk);
        hsel = sel; hhl = hl; hd_in = wb; hcs_n = !cs; hrw = rd;
        repeat (3) @(negedge clk);
        if (use_as) begin
            has_n = 1'b0;
            repeat (3) @(negedge clk);
            has_n = 1'b1;
            hsel = ~sel; hhl = !hl;
            repeat (3) @(negedge clk);
        end
        if (use_rw) hds_n = 1'b0;
        else if (rd) hrd_n = 1'b0;
        else hwr_n = 1'b0;
        #1;
        last_drop = !hrdy;
        last_low = 0;
        @(negedge clk);
        while (!hrdy && last_low < 100) begin
            last_low++;
            @(negedge clk);
        end
        rb = hd_out;
        last_oe = hd_oe;
        hrd_n = 1'b1; hwr_n = 1'b1; hds_n = 1'b1; hcs_n = 1'b1;
        hsel = sel; hhl = hl;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_word(input logic [1:0] sel, input logic [15:0] w);
        logic [7:0] d;
        host_op(1'b0, sel, 1'b0, w[7:0], 1'b1, d);
        host_op(1'b0, sel, 1'b1, w[15:8], 1'b1, d);
    endtask

    task automatic rd_word(input logic [1:0] sel, output logic [15:0] w, output int low);
        logic [7:0] lo, hi;
        host_op(1'b1, sel, 1'b0, 8'h00, 1'b1, lo);
        low = last_low;
        host_op(1'b1, sel, 1'b1, 8'h00, 1'b1, hi);
        w = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [7:0] d;
        int low, minlow, bad, w0, r0;

        for (int i = 0; i < (1 << AW); i++) ram[i] = 16'hDEAD;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hrdy && hint_n && !core_irq && !mem_en && !hd_oe, "R1",
              {hrdy, hint_n, core_irq, mem_en, hd_oe}, 5'b11000);

        // R4 address register write and read back
        wr_word(2'b10, 16'h0000);
        rd_word(2'b10, w, low);
        check(w == 16'h0000, "R4", w, 0);

        // R2 first byte alone does not write
        w0 = wr_cnt;
        host_op(1'b0, 2'b01, 1'b0, pat(0, 5)[7:0], 1'b1, d);
        check(wr_cnt == w0, "R2", wr_cnt, w0);
        host_op(1'b0, 2'b01, 1'b1, pat(0, 5)[15:8], 1'b1, d);
        check(wr_cnt == w0 + 1 && ram[0] == pat(0, 5), "R2", ram[0], pat(0, 5));
        for (int i = 1; i < NW; i++) wr_word(2'b01, pat(i, 5));
        bad = 0;
        for (int i = 0; i < NW; i++) if (ram[i] != pat(i, 5)) bad++;
        check(bad == 0, "R2", bad, 0);
        // R4 auto-increment reached NW
        rd_word(2'b10, w, low);
        check(w == NW, "R4", w, NW);

        // R3 read back, one fetch per word
        wr_word(2'b10, 16'h0000);
        r0 = rd_cnt; bad = 0; minlow = 1000;
        for (int i = 0; i < NW; i++) begin
            rd_word(2'b01, w, low);
            if (w != pat(i, 5)) bad++;
            if (low < minlow) minlow = low;
        end
        check(bad == 0, "R3", bad, 0);
        check(rd_cnt - r0 == NW, "R3", rd_cnt - r0, NW);
        check(last_oe, "R3", last_oe, 1);
        // R9 ready low for memory access
        check(minlow >= 2, "R9", minlow, 2);
        check(last_drop, "R9", last_drop, 1);

        // R4 fixed window does not increment
        wr_word(2'b10, 16'h0007);
        rd_word(2'b11, w, low);
        check(w == pat(7, 5), "R4", w, pat(7, 5));
        rd_word(2'b11, w, low);
        check(w == pat(7, 5), "R4", w, pat(7, 5));
        rd_word(2'b10, w, low);
        check(w == 16'h0007, "R4", w, 7);

        // R5 host-to-core interrupt
        wr_word(2'b00, 16'h0001);
        check(core_irq, "R5", core_irq, 1);
        @(negedge clk); core_irq_ack = 1'b1;
        @(negedge clk); core_irq_ack = 1'b0;
        check(!core_irq, "R5", core_irq, 0);

        // R6 core-to-host interrupt
        @(negedge clk); core_hint_set = 1'b1;
        @(negedge clk); core_hint_set = 1'b0;
        check(!hint_n, "R6", hint_n, 0);
        rd_word(2'b00, w, low);
        check(w == 16'h0002, "R6", w, 2);
        wr_word(2'b00, 16'h0002);
        check(hint_n, "R6", hint_n, 1);

        // R7 single strobe with direction line
        use_rw = 1'b1;
        wr_word(2'b10, 16'd40);
        for (int i = 0; i < 8; i++) wr_word(2'b01, pat(i, 99));
        wr_word(2'b10, 16'd40);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            rd_word(2'b01, w, low);
            if (w != pat(i, 99)) bad++;
        end
        check(bad == 0, "R7", bad, 0);
        use_rw = 1'b0;

        // R8 address-strobe latching of select lines
        use_as = 1'b1;
        wr_word(2'b10, 16'd60);
        for (int i = 0; i < 4; i++) wr_word(2'b01, pat(i, 321));
        wr_word(2'b10, 16'd60);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            rd_word(2'b01, w, low);
            if (w != pat(i, 321)) bad++;
        end
        check(bad == 0, "R8", bad, 0);
        use_as = 1'b0;

        // R10 deselected strobes ignored
        w0 = wr_cnt;
        host_op(1'b0, 2'b11, 1'b1, 8'h55, 1'b0, d);
        check(wr_cnt == w0, "R10", wr_cnt, w0);
        check(!last_drop, "R10", last_drop, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule